// File: doc/BRIEF.md
# Configurable Byte Order Converter

The block moves a 32-bit word between a memory byte layout and a native numeric value by permuting whole bytes. A two-bit mode picks one of four permutations: identity, full reversal of the four bytes, exchange of the two 16-bit halves, or exchange of the two bytes inside each half. Together these cover the big-endian, little-endian and both mixed-endian layouts. In a mixed-endian layout, the order of bytes inside a 16-bit unit differs from the order of the units inside the word.

The bit order inside each byte never changes. Each mode is its own inverse, so one block serves both the load direction and the store direction. A parameter chooses between a purely combinational path and a single output register. In the registered variant, the valid flag and the data both trail the inputs by one cycle, and the valid flag clears on reset.

Top module: `byte_order_conv`

## Requirements
- R1: Mode 2'b00 passes the word through unchanged.
- R2: Mode 2'b01 reverses all four bytes. Input byte k, meaning bits [8k+7:8k], appears at output byte 3-k. For example, 0x0A0B0C0D becomes 0x0D0C0B0A.
- R3: Mode 2'b10 exchanges the 16-bit halves. For example, 0x0A0B0C0D becomes 0x0C0D0A0B.
- R4: Mode 2'b11 exchanges the two bytes inside each 16-bit half. For example, 0x0A0B0C0D becomes 0x0B0A0D0C.
- R5: Bits inside each byte keep their order in every mode. Each output byte equals exactly one input byte.
- R6: Applying any mode twice returns the original word.
- R7: With REG_OUT=1, data_o and valid_o show the inputs of the previous clock edge, one cycle of latency.
- R8: While rst_ni is low, valid_o is 0. valid_o stays 0 until a valid input has been registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input word qualifier |
| mode_i | input | 2 | Permutation select (00 pass, 01 reverse, 10 half swap, 11 in-half swap) |
| data_i | input | 32 | Input word |
| valid_o | output | 1 | Output word qualifier |
| data_o | output | 32 | Permuted word |

## Verification
A wrong byte selection shows on data_o on the very next cycle as a misplaced byte. Using four distinct byte values in every directed pattern makes any swap of two lanes visible. A stale or mis-clocked output register shows as data_o or valid_o carrying the word from two cycles back, or the current word. This is caught because the stimulus changes the word and the mode every cycle. A reset fault shows as valid_o high during or directly after reset.

// File: rtl/byte_order_pkg.sv
package byte_order_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ORD_PASS  = 2'b00,
    ORD_REV   = 2'b01,
    ORD_HSWAP = 2'b10,
    ORD_BSWAP = 2'b11
  } order_mode_e;
endpackage

// File: rtl/byte_lane_mux.sv
module byte_lane_mux
  import byte_order_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [1:0]              mode_i,
  input  logic [LANES*BYTE_W-1:0] data_i,
  output logic [LANES*BYTE_W-1:0] data_o
);
  localparam int unsigned HALF = LANES / 2;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int unsigned SRC_REV = LANES - 1 - k;
    localparam int unsigned SRC_HSW = (k + HALF) % LANES;
    localparam int unsigned SRC_BSW = k ^ 1;

    always_comb begin
      unique case (order_mode_e'(mode_i))
        ORD_PASS:  data_o[k*BYTE_W +: BYTE_W] = data_i[k*BYTE_W +: BYTE_W];
        ORD_REV:   data_o[k*BYTE_W +: BYTE_W] = data_i[SRC_REV*BYTE_W +: BYTE_W];
        ORD_HSWAP: data_o[k*BYTE_W +: BYTE_W] = data_i[SRC_HSW*BYTE_W +: BYTE_W];
        default:   data_o[k*BYTE_W +: BYTE_W] = data_i[SRC_BSW*BYTE_W +: BYTE_W];
      endcase
    end
  end

  // R6 involution: the same mode applied again restores the word
  logic [LANES*BYTE_W-1:0] twice;
  for (genvar k = 0; k < LANES; k++) begin : g_inv
    localparam int unsigned SRC_REV = LANES - 1 - k;
    localparam int unsigned SRC_HSW = (k + HALF) % LANES;
    localparam int unsigned SRC_BSW = k ^ 1;

    always_comb begin
      unique case (order_mode_e'(mode_i))
        ORD_PASS:  twice[k*BYTE_W +: BYTE_W] = data_o[k*BYTE_W +: BYTE_W];
        ORD_REV:   twice[k*BYTE_W +: BYTE_W] = data_o[SRC_REV*BYTE_W +: BYTE_W];
        ORD_HSWAP: twice[k*BYTE_W +: BYTE_W] = data_o[SRC_HSW*BYTE_W +: BYTE_W];
        default:   twice[k*BYTE_W +: BYTE_W] = data_o[SRC_BSW*BYTE_W +: BYTE_W];
      endcase
    end
  end

  always_comb begin
    AST_SELF_INVERSE: assert (twice == data_i);  // R6
    AST_BYTE_PRESERVED: assert (^data_o == ^data_i);  // R5
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned WIDTH   = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        data_o  <= '0;
      end else begin
        valid_o <= valid_i;
        data_o  <= data_i;
      end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);  // R7
    AST_DATA_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> data_o == $past(data_i));  // R7
    AST_RESET_CLEAR: assert property (@(posedge clk_i)
      !rst_ni |-> !valid_o);  // R8
  end else begin : g_comb
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end
endmodule

// File: rtl/byte_order_conv.sv
module byte_order_conv
  import byte_order_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              mode_i,
  input  logic [LANES*BYTE_W-1:0] data_i,
  output logic                    valid_o,
  output logic [LANES*BYTE_W-1:0] data_o
);
  localparam int unsigned WIDTH = LANES * BYTE_W;

  logic [WIDTH-1:0] perm;

  byte_lane_mux #(.LANES(LANES)) u_mux (
    .mode_i (mode_i),
    .data_i (data_i),
    .data_o (perm)
  );

  out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (perm),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  always_comb begin
    if (mode_i == 2'b00) AST_PASS_IDENTITY: assert (perm == data_i);  // R1
  end
endmodule

// File: tb/byte_order_conv_tb_top.sv
module byte_order_conv_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [31:0] data_i = '0;
  logic        valid_o;
  logic [31:0] data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  byte_order_conv dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .data_i(data_i), .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic [31:0] ref_perm(input logic [1:0] m, input logic [31:0] d);
    case (m)
      2'b00:   return d;
      2'b01:   return {d[7:0], d[15:8], d[23:16], d[31:24]};
      2'b10:   return {d[15:0], d[31:16]};
      default: return {d[23:16], d[31:24], d[7:0], d[15:8]};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive before edge, sample after the registering edge
  task automatic apply(input logic v, input logic [1:0] m, input logic [31:0] d);
    @(negedge clk_i);
    valid_i = v; mode_i = m; data_i = d;
    @(negedge clk_i);
  endtask

  task automatic req_of(input logic [1:0] m, output string s);
    case (m)
      2'b00: s = "R1";
      2'b01: s = "R2";
      2'b10: s = "R3";
      default: s = "R4";
    endcase
  endtask

  initial begin
    string r;
    logic [31:0] first;
    void'($urandom(32'd1234));
    #1;
    check("R8 reset valid", {31'd0, valid_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    check("R8 reset valid held", {31'd0, valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 post-reset valid", {31'd0, valid_o}, 32'd0);

    apply(1, 2'b00, 32'h0A0B0C0D); check("R1", data_o, 32'h0A0B0C0D);
    check("R7 valid", {31'd0, valid_o}, 32'd1);
    apply(1, 2'b01, 32'h0A0B0C0D); check("R2", data_o, 32'h0D0C0B0A);
    apply(1, 2'b10, 32'h0A0B0C0D); check("R3", data_o, 32'h0C0D0A0B);
    apply(1, 2'b11, 32'h0A0B0C0D); check("R4", data_o, 32'h0B0A0D0C);
    apply(0, 2'b01, 32'h80402010); check("R5", data_o, 32'h10204080);
    check("R7 valid low", {31'd0, valid_o}, 32'd0);

    // R7: one-cycle latency with back-to-back changing words
    @(negedge clk_i);
    valid_i = 1; mode_i = 2'b01; data_i = 32'h11223344;
    @(negedge clk_i);
    check("R7 latency a", data_o, 32'h44332211);
    valid_i = 0; mode_i = 2'b10; data_i = 32'h55667788;
    @(negedge clk_i);
    check("R7 latency b", data_o, 32'h77885566);
    check("R7 valid b", {31'd0, valid_o}, 32'd0);

    // R6: apply each mode twice
    for (int m = 0; m < 4; m++) begin
      logic [31:0] w;
      w = $urandom;
      apply(1, m[1:0], w);
      first = data_o;
      apply(1, m[1:0], first);
      check("R6", data_o, w);
    end

    for (int i = 0; i < 200; i++) begin
      logic [1:0] m;
      logic [31:0] w;
      logic v;
      m = 2'($urandom);
      w = $urandom;
      v = 1'($urandom);
      apply(v, m, w);
      req_of(m, r);
      check(r, data_o, ref_perm(m, w));
      check("R7 valid", {31'd0, valid_o}, {31'd0, v});
    end

    // R8: reset mid-stream
    @(negedge clk_i);
    valid_i = 1;
    rst_ni = 0;
    #1;
    check("R8 async clear", {31'd0, valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1;
    valid_i = 0;
    @(negedge clk_i);
    check("R8 after reset", {31'd0, valid_o}, 32'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule